// File: doc/BRIEF.md
# Dual-Clock Asynchronous FIFO

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes words on its own clock with a write strobe and a full flag. A consumer pulls words on a second, independent clock with a read strobe and an empty flag. Each side has its own active-low reset.

Each side keeps a binary pointer that addresses the storage array and a Gray-coded copy of that pointer. Only the Gray copy is sent to the opposite domain, through a chain of synchronizer flops. The Gray coding means a pointer sampled mid-change is off by at most one position. Full and empty are registered look-ahead flags. Each one compares the pointer value that the coming edge will load against the synchronized pointer from the other side. The flag is therefore correct in the same cycle as the access that causes it. The storage array is written on the write clock. It is read combinationally, so the head word is on the read data output whenever the FIFO is not empty.

Top module: `afifo_top`

## Requirements
- R1: While a side's reset is held, and after it is released, `rempty` is 1 and `wfull` is 0 until a write is accepted.
- R2: Words come out on `rdata` in the order they were accepted on `wdata`, none lost and none repeated, whatever the strobe pattern on either side.
- R3: A write strobe at a write-clock edge where `wfull` is 1 has no effect: the word is not stored and no later read returns it.
- R4: A read strobe at a read-clock edge where `rempty` is 1 has no effect: the read pointer does not move, so the next word written is the next word read.
- R5: With no reads, the FIFO accepts exactly 16 words (2^ADDR_W). `wfull` goes to 1 at the write-clock edge that accepts the 16th word. `wfull` rises only at an edge with an accepted write.
- R6: `rempty` goes to 1 at the read-clock edge of the read that removes the last stored word. It rises only at an edge with an accepted read.
- R7: After a write into an empty FIFO, `rempty` is still 1 after the second rising read-clock edge that follows the write edge. It is 0 after the third such edge (two synchronizer stages plus the flag register).
- R8: After a read from a full FIFO, `wfull` is still 1 after the second rising write-clock edge that follows the read edge. It is 0 after the third such edge.
- R9: While `rempty` is 0, `rdata` shows the oldest stored word without any read strobe. It changes to the next word once a read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| winc | input | 1 | Write strobe, sampled on the rising edge of `wclk` |
| wdata | input | DATA_W (8) | Word to store |
| wfull | output | 1 | Registered full flag, write domain |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| rinc | input | 1 | Read strobe, sampled on the rising edge of `rclk` |
| rdata | output | DATA_W (8) | Oldest stored word, combinational from the read address |
| rempty | output | 1 | Registered empty flag, read domain |

## Verification
A write or read changes its own side's flag at the same edge that accepts it. `rdata` moves to the next word right after an accepted read, with no register in between. The opposite side's flag changes at the third edge of its own clock after the pointer move. The bench drives strobes on falling edges and decides acceptance from the flag value it sees then. Flag checks are sampled 1 ns after the counted rising edges. The two clock periods are chosen so that their rising edges never coincide, which keeps that edge count unambiguous.

// File: rtl/afifo_pkg.sv
`timescale 1ns/100ps
package afifo_pkg;
   localparam int unsigned MAX_PTR_W = 32;

   typedef logic [MAX_PTR_W-1:0] ptr_word_t;

   // Binary to reflected Gray code.
   function automatic ptr_word_t to_gray(input ptr_word_t b);
      return b ^ (b >> 1);
   endfunction
endpackage

// File: rtl/afifo_mem.sv
`timescale 1ns/100ps
module afifo_mem #(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 4
) (
   input  logic          wclk,
   input  logic          wen,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (wen) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/afifo_sync.sv
`timescale 1ns/100ps
module afifo_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/afifo_wr_ctl.sv
`timescale 1ns/100ps
module afifo_wr_ctl
   import afifo_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          winc,
   input  logic [AW:0]   rgray_s,
   output logic [AW:0]   wbin,
   output logic [AW:0]   wgray,
   output logic          wfull,
   output logic [AW-1:0] waddr,
   output logic          wen
);
   localparam int unsigned PW = AW + 1;

   logic [PW-1:0] bin_nx;
   logic [PW-1:0] gray_nx;
   logic [PW-1:0] far_side;
   logic          full_nx;

   assign wen     = winc & ~wfull;
   assign bin_nx  = wbin + PW'(wen);
   assign gray_nx = PW'(to_gray(ptr_word_t'(bin_nx)));
   // one lap ahead of the reader: top two Gray bits inverted, rest equal
   assign far_side = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
   assign full_nx  = (gray_nx == far_side);
   assign waddr    = wbin[AW-1:0];

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
         wfull <= 1'b0;
      end else begin
         wbin  <= bin_nx;
         wgray <= gray_nx;
         wfull <= full_nx;
      end
   end
endmodule

// File: rtl/afifo_rd_ctl.sv
`timescale 1ns/100ps
module afifo_rd_ctl
   import afifo_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          rinc,
   input  logic [AW:0]   wgray_s,
   output logic [AW:0]   rbin,
   output logic [AW:0]   rgray,
   output logic          rempty,
   output logic [AW-1:0] raddr
);
   localparam int unsigned PW = AW + 1;

   logic          ren;
   logic [PW-1:0] bin_nx;
   logic [PW-1:0] gray_nx;

   assign ren     = rinc & ~rempty;
   assign bin_nx  = rbin + PW'(ren);
   assign gray_nx = PW'(to_gray(ptr_word_t'(bin_nx)));
   assign raddr   = rbin[AW-1:0];

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin   <= '0;
         rgray  <= '0;
         rempty <= 1'b1;
      end else begin
         rbin   <= bin_nx;
         rgray  <= gray_nx;
         rempty <= (gray_nx == wgray_s);
      end
   end
endmodule

// File: rtl/afifo_top.sv
`timescale 1ns/100ps
module afifo_top #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              winc,
   input  logic [DATA_W-1:0] wdata,
   output logic              wfull,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              rinc,
   output logic [DATA_W-1:0] rdata,
   output logic              rempty
);
   localparam int unsigned PW = ADDR_W + 1;

   generate
      if (ADDR_W < 2 || PW > afifo_pkg::MAX_PTR_W) begin : g_bad_addr
         $error("afifo_top: ADDR_W must lie in 2..31");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("afifo_top: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("afifo_top: DATA_W must be at least 1");
      end
   endgenerate

   logic [PW-1:0]     wbin, wgray, rbin, rgray;
   logic [PW-1:0]     wgray_s, rgray_s;
   logic [ADDR_W-1:0] waddr, raddr;
   logic              wen;

   afifo_wr_ctl #(.AW(ADDR_W)) u_wr (
      .wclk(wclk), .wrst_n(wrst_n), .winc(winc), .rgray_s(rgray_s),
      .wbin(wbin), .wgray(wgray), .wfull(wfull), .waddr(waddr), .wen(wen)
   );

   afifo_rd_ctl #(.AW(ADDR_W)) u_rd (
      .rclk(rclk), .rrst_n(rrst_n), .rinc(rinc), .wgray_s(wgray_s),
      .rbin(rbin), .rgray(rgray), .rempty(rempty), .raddr(raddr)
   );

   afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
   );

   afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
   );

   afifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
      .wclk(wclk), .wen(wen), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata)
   );
endmodule

// File: rtl/afifo_chk.sv
`timescale 1ns/100ps
module afifo_chk #(
   parameter int unsigned PW = 5
) (
   input logic          wclk,
   input logic          wrst_n,
   input logic          winc,
   input logic          wfull,
   input logic [PW-1:0] wbin,
   input logic [PW-1:0] wgray,
   input logic          rclk,
   input logic          rrst_n,
   input logic          rinc,
   input logic          rempty,
   input logic [PW-1:0] rbin,
   input logic [PW-1:0] rgray
);
   // R3
   no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
      (wfull && winc) |=> $stable(wbin));

   // R4
   no_underflow_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
      (rempty && rinc) |=> $stable(rbin));

   // R5
   full_rise_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
      $rose(wfull) |-> $past(winc));

   // R6
   empty_rise_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
      $rose(rempty) |-> $past(rinc));

   // R2
   wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

   // R2
   rgray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
      $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind afifo_top afifo_chk #(.PW(ADDR_W + 1)) u_chk (
   .wclk(wclk), .wrst_n(wrst_n), .winc(winc), .wfull(wfull),
   .wbin(wbin), .wgray(wgray),
   .rclk(rclk), .rrst_n(rrst_n), .rinc(rinc), .rempty(rempty),
   .rbin(rbin), .rgray(rgray)
);

// File: tb/tb_afifo_top.sv
`timescale 1ns/100ps
module tb_afifo_top;
   localparam int DW = 8;

   logic          wclk = 1'b0, rclk = 1'b0;
   logic          wrst_n = 1'b0, rrst_n = 1'b0;
   logic          winc = 1'b0, rinc = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          wfull, rempty;

   int n_chk = 0;
   int n_fail = 0;
   logic [DW-1:0] model_q [$];

   // write clock 50 MHz; read clock period 27 ns, rising edges at 13.5 + 27k
   always #10   wclk = ~wclk;
   always #13.5 rclk = ~rclk;

   afifo_top dut (
      .wclk(wclk), .wrst_n(wrst_n), .winc(winc), .wdata(wdata), .wfull(wfull),
      .rclk(rclk), .rrst_n(rrst_n), .rinc(rinc), .rdata(rdata), .rempty(rempty)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] fill_word(input int i);
      return DW'(8'h10 + i);
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   // random traffic with the in-order reference queue
   task automatic rand_phase(input int wpct, input int rpct, input int ncyc);
      fork
         begin
            for (int i = 0; i < ncyc; i++) begin
               @(negedge wclk);
               winc  = (($urandom % 100) < wpct);
               wdata = DW'($urandom);
               if (winc && !wfull) model_q.push_back(wdata);
            end
            @(negedge wclk) winc = 1'b0;
         end
         begin
            for (int i = 0; i < ncyc; i++) begin
               @(negedge rclk);
               rinc = (($urandom % 100) < rpct);
               if (rinc && !rempty) begin
                  if (model_q.size() == 0) chk(1'b0, "R2 read with empty model", 32'(rdata), 0);
                  else chk(rdata == model_q[0], "R2 order", 32'(rdata), 32'(model_q[0]));
                  if (model_q.size() != 0) void'(model_q.pop_front());
               end
            end
            @(negedge rclk) rinc = 1'b0;
         end
      join
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      // R1 during reset
      repeat (3) @(negedge wclk);
      chk(rempty == 1'b1, "R1 empty in reset", 32'(rempty), 1);
      chk(wfull  == 1'b0, "R1 full in reset", 32'(wfull), 0);
      @(negedge wclk) wrst_n = 1'b1;
      @(negedge rclk) rrst_n = 1'b1;
      repeat (5) @(negedge rclk);
      chk(rempty == 1'b1, "R1 empty after reset", 32'(rempty), 1);
      chk(wfull  == 1'b0, "R1 full after reset", 32'(wfull), 0);

      // R7: empty drop latency after a single write
      fork
         begin
            @(negedge wclk);
            winc = 1'b1; wdata = 8'hA5;
            @(posedge wclk);
            #1 winc = 1'b0;
         end
         begin
            @(negedge wclk);
            @(posedge wclk);
            @(posedge rclk); @(posedge rclk);
            #1 chk(rempty == 1'b1, "R7 empty after 2 rclk", 32'(rempty), 1);
            @(posedge rclk);
            #1 chk(rempty == 1'b0, "R7 empty after 3 rclk", 32'(rempty), 0);
         end
      join
      // R9: head word visible without a strobe
      @(negedge rclk);
      chk(rdata == 8'hA5, "R9 head visible", 32'(rdata), 32'hA5);
      rinc = 1'b1;
      @(negedge rclk) rinc = 1'b0;
      chk(rempty == 1'b1, "R6 empty at last read", 32'(rempty), 1);
      repeat (8) @(negedge wclk);

      // R5: capacity and full timing
      for (int i = 0; i < 16; i++) begin
         @(negedge wclk);
         chk(wfull == 1'b0, "R5 not full before 16", 32'(wfull), 0);
         winc = 1'b1; wdata = fill_word(i);
      end
      for (int i = 0; i < 4; i++) begin
         @(negedge wclk);
         chk(wfull == 1'b1, i == 0 ? "R5 full at 16" : "R3 stays full", 32'(wfull), 1);
         wdata = 8'hEE;   // dropped: FIFO full
      end
      @(negedge wclk) winc = 1'b0;
      repeat (6) @(negedge rclk);

      // R8: full drop latency after one read
      @(negedge rclk);
      chk(rdata == fill_word(0), "R2 fill order", 32'(rdata), 32'(fill_word(0)));
      fork
         begin
            rinc = 1'b1;
            @(posedge rclk);
            #1 rinc = 1'b0;
         end
         begin
            @(posedge rclk);
            @(posedge wclk); @(posedge wclk);
            #1 chk(wfull == 1'b1, "R8 full after 2 wclk", 32'(wfull), 1);
            @(posedge wclk);
            #1 chk(wfull == 1'b0, "R8 full after 3 wclk", 32'(wfull), 0);
         end
      join
      for (int i = 1; i < 16; i++) begin
         @(negedge rclk);
         chk(rempty == 1'b0, "R6 not empty before last", 32'(rempty), 0);
         chk(rdata == fill_word(i), "R2 fill order", 32'(rdata), 32'(fill_word(i)));
         rinc = 1'b1;
      end
      // R3: the dropped 0xEE words never appear
      @(negedge rclk);
      chk(rempty == 1'b1, "R3 R6 empty after 16 reads", 32'(rempty), 1);
      // R4: reads while empty are ignored
      for (int i = 0; i < 3; i++) begin
         @(negedge rclk);
         chk(rempty == 1'b1, "R4 empty held", 32'(rempty), 1);
      end
      rinc = 1'b0;
      @(negedge wclk);
      winc = 1'b1; wdata = 8'h5A;
      @(negedge wclk) winc = 1'b0;
      repeat (6) @(negedge rclk);
      chk(rempty == 1'b0, "R4 word after empty reads", 32'(rempty), 0);
      chk(rdata == 8'h5A, "R4 pointer unmoved", 32'(rdata), 32'h5A);
      rinc = 1'b1;
      @(negedge rclk) rinc = 1'b0;
      chk(rempty == 1'b1, "R6 empty again", 32'(rempty), 1);
      repeat (6) @(negedge wclk);

      // R2: random bursts, write-heavy, read-heavy, balanced
      rand_phase(90, 40, 600);
      rand_phase(40, 90, 600);
      rand_phase(70, 70, 800);
      repeat (8) @(negedge rclk);
      while (!rempty) begin
         if (model_q.size() == 0) begin
            chk(1'b0, "R2 extra word", 32'(rdata), 0);
            break;
         end
         chk(rdata == model_q[0], "R2 drain order", 32'(rdata), 32'(model_q[0]));
         void'(model_q.pop_front());
         rinc = 1'b1;
         @(negedge rclk) rinc = 1'b0;
      end
      chk(model_q.size() == 0, "R2 nothing lost", model_q.size(), 0);
      finish_run();
   end
endmodule